// File: doc/BRIEF.md
# Scan Conversion Sequencer with Bus-Clock Holding

This block decides, once a valid read address has arrived on a two-wire serial bus, when each analog conversion begins and which input channel it samples. It watches pulses marking the bus clock's rising and falling edges, drives the track and start strobes for a converter modelled outside the block, and writes every finished result into a small result memory in the order the conversions were made.

Two timing styles are supported. With the internally timed style, the block holds the bus clock low while it runs the whole scan. It lets the clock go only after the last result of the scan is stored. With the bus-timed style, the conversion pace comes from bus clock edges, and conversions repeat back to back until the master ends the transfer. The mode bit, the two-bit scan code and the channel select are captured at the moment the address is accepted, so a scan that is already running is not disturbed by later changes to them.

Top module: `scan_seq`

## Requirements
- R1: After reset, `chan` is 0 and `track`, `conv_start`, `scl_hold`, `mem_we` and `result_cnt` are all 0.
- R2: With `ext_clk_mode`=0 at `addr_valid`, `track` rises in the cycle after `addr_valid`. At the second `scl_fall` pulse after that, `track` drops, `conv_start` pulses for one cycle and `scl_hold` rises, all in the cycle after that pulse. `scl_hold` and `track` are never high together.
- R3: In the internally timed mode, `scl_hold` stays high from the first conversion until the cycle after the `conv_done` of the last conversion of the scan. `scl_hold` falls only after that write, on `bus_end`, or on a new `addr_valid`. Each non-final `conv_done` starts the next conversion (`conv_start`) in the next cycle.
- R4: Scan code 00 converts channels 0, 1, ... up to `cs_sel`, in ascending order.
- R5: Scan code 01 in the internally timed mode converts the `cs_sel` channel eight times. Writes go to memory addresses 0,1,0,1,... and `result_cnt` counts written results, saturating at the memory depth of 2.
- R6: Scan code 11, and the reserved code 10, convert the `cs_sel` channel once.
- R7: With `ext_clk_mode`=1 at `addr_valid`, `track` rises after the first `scl_rise` pulse. `conv_start` pulses after the third `scl_rise` pulse. `scl_hold` stays 0 throughout.
- R8: In the bus-timed mode, each `conv_done` is followed by tracking and then a new `conv_start` after two further `scl_rise` pulses. Scan code 00 cycles through channels 0..`cs_sel` and wraps. Scan codes 01 and 11 repeat the `cs_sel` channel.
- R9: `bus_end` (stop, not-acknowledge or repeated start) returns the block to idle. In the next cycle `scl_hold`, `track` and `conv_start` are 0, and a later `scl_fall`/`scl_rise` starts no conversion.
- R10: When `conv_done` and `bus_end` arrive in the same cycle, no memory write occurs (`mem_we`=0) and the block goes idle.
- R11: The mode bit, scan code and channel select are captured at `addr_valid`. Changing the inputs during a scan has no effect on the scan.
- R12: `conv_done` outside an active conversion produces no write and leaves `result_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | One-cycle pulse: valid read address seen at the 8th bus clock rise |
| scl_rise | input | 1 | One-cycle pulse per bus clock rising edge |
| scl_fall | input | 1 | One-cycle pulse per bus clock falling edge |
| bus_end | input | 1 | One-cycle pulse on stop, not-acknowledge or repeated start |
| ext_clk_mode | input | 1 | 0 = internally timed (default), 1 = bus-timed |
| scan_mode | input | 2 | 00 sweep, 01 repeat eight, 10 reserved (acts as 11), 11 single |
| cs_sel | input | 1 | Selected channel |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| chan | output | 1 | Channel for the current conversion |
| track | output | 1 | Input tracking phase |
| conv_start | output | 1 | One-cycle conversion start strobe |
| scl_hold | output | 1 | Hold the bus clock low |
| mem_we | output | 1 | Result memory write enable |
| mem_addr | output | 1 | Result memory write address |
| mem_wdata | output | 12 | Result memory write data |
| result_cnt | output | 2 | Number of valid results in memory |

## Verification
A conversion can complete in the same cycle that the master ends the transfer, so `conv_done` and `bus_end` can coincide. The bench starts an internally timed single conversion and raises both pulses together. It checks in that same cycle that `mem_we` stays low. One cycle later it checks that the clock hold is released, that `result_cnt` is unchanged, and that further bus clock edges start nothing.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an address
    ST_ITRK,   // internal mode, tracking until the 9th falling edge
    ST_ETRK,   // bus-timed mode, counting rising edges
    ST_CONV,   // conversion in progress
    ST_HELD    // internal scan complete, results held
  } seq_state_e;
endpackage

// File: rtl/scan_seq_decode.sv
module scan_seq_decode #(
  parameter int REPEAT = 8,
  parameter int CH_W   = 1,
  parameter int CNT_W  = 4
) (
  input  logic             ext_mode,
  input  logic [1:0]       scan,
  input  logic [CH_W-1:0]  cs,
  output logic             sweep,
  output logic [CNT_W-1:0] last_idx
);
  always_comb begin
    sweep = (scan == 2'b00);
    if (sweep)
      last_idx = CNT_W'(cs);
    else if (scan == 2'b01 && !ext_mode)
      last_idx = CNT_W'(REPEAT - 1);
    else
      last_idx = '0;  // single, reserved, or bus-timed repeat
  end
endmodule

// File: rtl/scan_seq_wrptr.sv
module scan_seq_wrptr #(
  parameter int DEPTH  = 2,
  parameter int PTR_W  = 1,
  parameter int RCNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  output logic [PTR_W-1:0]  ptr,
  output logic [RCNT_W-1:0] cnt
);
  logic [PTR_W-1:0]  ptr_d;
  logic [RCNT_W-1:0] cnt_d;
  logic              upd;

  always_comb begin
    upd   = clr | we;
    ptr_d = ptr;
    cnt_d = cnt;
    if (clr) begin
      ptr_d = '0;
      cnt_d = '0;
    end else if (we) begin
      ptr_d = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      if (cnt != RCNT_W'(DEPTH)) cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (upd) begin
      ptr <= ptr_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 2,
  parameter int REPEAT = 8,
  parameter int RES_W  = 12,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_end,
  input  logic              ext_clk_mode,
  input  logic [1:0]        scan_mode,
  input  logic [CH_W-1:0]   cs_sel,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [CH_W-1:0]   chan,
  output logic              track,
  output logic              conv_start,
  output logic              scl_hold,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [RES_W-1:0]  mem_wdata,
  output logic [RCNT_W-1:0] result_cnt
);
  localparam int MAXN  = (REPEAT > NUM_CH) ? REPEAT : NUM_CH;
  localparam int CNT_W = $clog2(MAXN + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [1:0]       ecnt_q, ecnt_d;
  logic             start_q, start_d;
  logic             ext_q;
  logic [1:0]       scan_q;
  logic [CH_W-1:0]  cs_q;
  logic             sweep;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  // configuration captured with the address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      scan_q <= 2'b11;
      cs_q   <= '0;
    end else if (addr_valid) begin
      ext_q  <= ext_clk_mode;
      scan_q <= scan_mode;
      cs_q   <= cs_sel;
    end
  end

  scan_seq_decode #(.REPEAT(REPEAT), .CH_W(CH_W), .CNT_W(CNT_W)) dec_i (
    .ext_mode (ext_q),
    .scan     (scan_q),
    .cs       (cs_q),
    .sweep    (sweep),
    .last_idx (last_idx)
  );

  assign at_last = (idx_q == last_idx);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ecnt_d  = ecnt_q;
    start_d = 1'b0;
    mem_we  = 1'b0;
    if (addr_valid) begin
      idx_d   = '0;
      ecnt_d  = '0;
      state_d = ext_clk_mode ? ST_ETRK : ST_ITRK;
    end else if (bus_end) begin
      ecnt_d  = '0;
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ITRK: if (scl_fall) begin
          if (ecnt_q == 2'd1) begin
            state_d = ST_CONV;
            start_d = 1'b1;
            ecnt_d  = '0;
          end else ecnt_d = ecnt_q + 2'd1;
        end
        ST_ETRK: if (scl_rise) begin
          if (ecnt_q == 2'd2) begin
            state_d = ST_CONV;
            start_d = 1'b1;
            ecnt_d  = '0;
          end else ecnt_d = ecnt_q + 2'd1;
        end
        ST_CONV: if (conv_done) begin
          mem_we = 1'b1;
          if (ext_q) begin
            idx_d   = at_last ? '0 : idx_q + 1'b1;
            ecnt_d  = 2'd1;
            state_d = ST_ETRK;
          end else if (at_last) begin
            state_d = ST_HELD;
          end else begin
            idx_d   = idx_q + 1'b1;
            start_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ecnt_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ecnt_q  <= ecnt_d;
      start_q <= start_d;
    end
  end

  scan_seq_wrptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .RCNT_W(RCNT_W)) wp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (addr_valid),
    .we    (mem_we),
    .ptr   (mem_addr),
    .cnt   (result_cnt)
  );

  assign chan       = sweep ? idx_q[CH_W-1:0] : cs_q;
  assign conv_start = start_q;
  assign scl_hold   = (state_q == ST_CONV) && !ext_q;
  assign track      = (state_q == ST_ITRK) || (state_q == ST_ETRK && ecnt_q != 2'd0);
  assign mem_wdata  = conv_result;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int DEPTH  = 2,
  parameter int RCNT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              bus_end,
  input logic              conv_start,
  input logic              scl_hold,
  input logic              track,
  input logic              mem_we,
  input logic              ext_q,
  input logic [RCNT_W-1:0] result_cnt
);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_cnt <= RCNT_W'(DEPTH));

  // R9
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_end && !addr_valid) |=> (!scl_hold && !track && !conv_start));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !ext_q) |-> scl_hold);

  // R2
  trk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !track);

  // R3
  hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_hold) && !$past(bus_end) && !$past(addr_valid)) |-> $past(mem_we));
endmodule

bind scan_seq scan_seq_chk #(.DEPTH(DEPTH), .RCNT_W(RCNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .bus_end    (bus_end),
  .conv_start (conv_start),
  .scl_hold   (scl_hold),
  .track      (track),
  .mem_we     (mem_we),
  .ext_q      (ext_q),
  .result_cnt (result_cnt)
);

// File: tb/scan_seq_tb_top.sv
module scan_seq_tb_top;
  logic clk, rst_n;
  logic addr_valid, scl_rise, scl_fall, bus_end, ext_clk_mode, conv_done;
  logic [1:0]  scan_mode;
  logic        cs_sel;
  logic [11:0] conv_result;
  logic        chan, track, conv_start, scl_hold, mem_we, mem_addr;
  logic [11:0] mem_wdata;
  logic [1:0]  result_cnt;
  int n_chk = 0, n_err = 0;

  scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_end(bus_end), .ext_clk_mode(ext_clk_mode),
    .scan_mode(scan_mode), .cs_sel(cs_sel), .conv_done(conv_done),
    .conv_result(conv_result), .chan(chan), .track(track),
    .conv_start(conv_start), .scl_hold(scl_hold), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .result_cnt(result_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic pulse_addr(input bit ext, input logic [1:0] sc, input logic cs);
    @(negedge clk);
    ext_clk_mode = ext; scan_mode = sc; cs_sel = cs; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic pulse_fall();
    @(negedge clk); scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic pulse_rise();
    @(negedge clk); scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); bus_end = 1'b1; @(negedge clk); bus_end = 1'b0;
  endtask

  task automatic finish_conv(input string rq, input int ech, input int eaddr, input int data);
    @(negedge clk);
    conv_done = 1'b1; conv_result = 12'(data);
    #1;
    chk(rq, "mem_we", mem_we, 1);
    chk(rq, "mem_addr", mem_addr, eaddr);
    chk(rq, "chan", chan, ech);
    chk(rq, "mem_wdata", mem_wdata, data);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic start_int(input logic [1:0] sc, input logic cs);
    pulse_addr(1'b0, sc, cs);
    chk("R2", "track after addr", track, 1);
    chk("R2", "hold before start", scl_hold, 0);
    pulse_fall();
    chk("R2", "no start at 8th fall", conv_start, 0);
    pulse_fall();
    chk("R2", "start at 9th fall", conv_start, 1);
    chk("R2", "hold at start", scl_hold, 1);
    chk("R2", "track ends", track, 0);
  endtask

  task automatic start_ext(input logic [1:0] sc, input logic cs);
    pulse_addr(1'b1, sc, cs);
    chk("R7", "no track before 9th rise", track, 0);
    pulse_rise();
    chk("R7", "track at 9th rise", track, 1);
    pulse_rise();
    chk("R7", "no start yet", conv_start, 0);
    pulse_rise();
    chk("R7", "start two cycles later", conv_start, 1);
    chk("R7", "no hold", scl_hold, 0);
  endtask

  task automatic ext_next();
    chk("R8", "track after result", track, 1);
    chk("R8", "no immediate start", conv_start, 0);
    pulse_rise();
    chk("R8", "no start after one rise", conv_start, 0);
    pulse_rise();
    chk("R8", "start after two rises", conv_start, 1);
    chk("R7", "no hold", scl_hold, 0);
  endtask

  task automatic t_reset();
    chk("R1", "chan", chan, 0);
    chk("R1", "track", track, 0);
    chk("R1", "conv_start", conv_start, 0);
    chk("R1", "scl_hold", scl_hold, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "result_cnt", result_cnt, 0);
  endtask

  task automatic t_single(input logic [1:0] sc, input logic cs);
    start_int(sc, cs);
    finish_conv("R6", cs, 0, 12'h5A0 + cs);
    chk("R3", "hold released", scl_hold, 0);
    chk("R6", "one result", result_cnt, 1);
    chk("R6", "no further start", conv_start, 0);
    pulse_fall();
    chk("R6", "stays finished", conv_start, 0);
  endtask

  task automatic t_sweep();
    start_int(2'b00, 1'b1);
    finish_conv("R4", 0, 0, 12'h111);
    chk("R3", "next start", conv_start, 1);
    chk("R3", "hold kept", scl_hold, 1);
    finish_conv("R4", 1, 1, 12'h222);
    chk("R3", "hold released", scl_hold, 0);
    chk("R4", "two results", result_cnt, 2);
  endtask

  task automatic t_repeat();
    start_int(2'b01, 1'b1);
    for (int k = 0; k < 8; k++) begin
      finish_conv("R5", 1, k % 2, 12'h300 + k);
      chk("R5", "result_cnt", result_cnt, (k + 1 > 2) ? 2 : k + 1);
      chk("R3", "hold", scl_hold, (k < 7) ? 1 : 0);
    end
  endtask

  task automatic t_ext_single();
    start_ext(2'b11, 1'b1);
    for (int k = 0; k < 3; k++) begin
      finish_conv("R8", 1, k % 2, 12'h400 + k);
      ext_next();
    end
    pulse_end();
    chk("R9", "track released", track, 0);
    chk("R9", "no hold", scl_hold, 0);
    @(negedge clk); conv_done = 1'b1; #1;
    chk("R12", "done ignored when idle", mem_we, 0);
    @(negedge clk); conv_done = 1'b0;
    chk("R12", "count kept", result_cnt, 2);
    pulse_rise(); pulse_rise(); pulse_rise();
    chk("R9", "no start after end", conv_start, 0);
  endtask

  task automatic t_ext_modes();
    start_ext(2'b01, 1'b0);
    finish_conv("R8", 0, 0, 12'h501);
    ext_next();
    finish_conv("R8", 0, 1, 12'h502);
    pulse_end();
    start_ext(2'b00, 1'b1);
    finish_conv("R8", 0, 0, 12'h601);
    ext_next();
    finish_conv("R8", 1, 1, 12'h602);
    ext_next();
    finish_conv("R8", 0, 0, 12'h603);
    pulse_end();
  endtask

  task automatic t_collide();
    start_int(2'b11, 1'b0);
    @(negedge clk);
    conv_done = 1'b1; bus_end = 1'b1; #1;
    chk("R10", "no write on collision", mem_we, 0);
    @(negedge clk);
    conv_done = 1'b0; bus_end = 1'b0;
    chk("R10", "hold released", scl_hold, 0);
    chk("R10", "no result", result_cnt, 0);
    pulse_fall(); pulse_fall();
    chk("R10", "idle after collision", conv_start, 0);
  endtask

  task automatic t_latch();
    start_int(2'b00, 1'b1);
    @(negedge clk);
    scan_mode = 2'b11; cs_sel = 1'b0; ext_clk_mode = 1'b1;
    finish_conv("R11", 0, 0, 12'h701);
    chk("R11", "scan continues", conv_start, 1);
    chk("R11", "hold kept", scl_hold, 1);
    finish_conv("R11", 1, 1, 12'h702);
    chk("R11", "scan ends", scl_hold, 0);
    @(negedge clk); conv_done = 1'b1; #1;
    chk("R12", "done ignored when held", mem_we, 0);
    @(negedge clk); conv_done = 1'b0;
    chk("R12", "count kept", result_cnt, 2);
    pulse_end();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; addr_valid = 1'b0; scl_rise = 1'b0; scl_fall = 1'b0;
    bus_end = 1'b0; ext_clk_mode = 1'b0; scan_mode = 2'b00; cs_sel = 1'b0;
    conv_done = 1'b0; conv_result = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(2'b11, 1'b1);
    t_single(2'b10, 1'b0);
    t_sweep();
    t_repeat();
    t_ext_single();
    t_ext_modes();
    t_collide();
    t_latch();
    report();
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule